// File: doc/BRIEF.md
# Self-Synchronizing PRBS Word Checker

This block verifies a pseudo-random test pattern on one receive lane. Each cycle it may accept a parallel data word. The first received bit is in the MSB. The block predicts the word it should see next by running the selected PRBS recurrence forward from the two words received before it. Because of this, it locks to the incoming sequence without a seed or an alignment step. Every compared word that differs from the prediction adds one to a 16-bit error counter and produces a one-cycle error pulse.

Software-like control reduces to a few strobes. The enable and the pattern select start a fresh measurement. A read strobe captures the accumulated count onto the count output and zeroes the counter in the same operation. Errors never cause the checker to give up its lock. It simply keeps comparing and counting.

Top module: `prbs_word_checker`

## Requirements
- R1: `pat_sel_i` selects the recurrence as follows. 0 gives s[n]=s[n-7]^s[n-6] (x^7+x^6+1). 1 gives s[n]=s[n-23]^s[n-18] (x^23+x^18+1). 2 and 3 both give s[n]=s[n-31]^s[n-28] (x^31+x^28+1). Words are 20 bits, first bit in bit 19. A correct stream of the selected sequence produces no errors.
- R2: After a restart, `sync_o` is low. It goes high the cycle after the second accepted word. The third accepted word is the first one compared.
- R3: A compared word with any number of wrong bits adds exactly one to the counter. `err_o` is high for the one cycle after that word is accepted.
- R4: With select 0 or 1, the 3 accepted words that follow a counted error are not compared. They only reseed the predictor. With 0xAAAAA repeated under select 0, one error is counted for every 4 compared-or-skipped words.
- R5: With select 2 or 3 there is no holdoff. Flipping bit 19 of one word in a correct stream counts exactly 2 errors: that word, and the next word, whose prediction uses the flipped bit.
- R6: The counter saturates at 0xFFFF and does not roll over.
- R7: A cycle with `rd_i` high loads the counter value onto `count_o` at that edge and sets the counter to zero. An error compared in that same cycle counts as 1 in the new period.
- R8: Errors never drop `sync_o`. A sequence other than the selected one keeps counting. With 0xAAAAA repeated under select 2, every compared word counts.
- R9: `en_i` low, or a change of `pat_sel_i`, clears the counter and drops `sync_o` at the next edge. The history restarts.
- R10: A cycle with `valid_i` low has no effect on the history, the comparisons or the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Verifier enable |
| pat_sel_i | input | 2 | Pattern select |
| data_i | input | 20 | Received word, first bit in MSB |
| valid_i | input | 1 | Word strobe |
| rd_i | input | 1 | Read-and-clear strobe |
| count_o | output | 16 | Count returned by the last read |
| sync_o | output | 1 | Predictor seeded and comparing |
| err_o | output | 1 | One-cycle pulse per counted error |

## Verification
A word accepted at edge t shows up in `err_o` and in the internal counter at that same edge t. `sync_o` rises at the edge that accepts the second word. A read issued in the cycle before edge r places the count on `count_o` at edge r. A select change or a low enable clears state at the next edge. The bench drives inputs on the falling clock edge and samples one half-cycle after the edge in question. That is the first point at which each of these registered results is due. Every expected count follows from counting accepted words after the sync point, with the holdoff skipping three of them where it applies.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

  typedef enum logic [1:0] {
    PAT_P7  = 2'd0,
    PAT_P23 = 2'd1,
    PAT_P31 = 2'd2,
    PAT_P31B = 2'd3
  } pat_e;

  localparam int NUM_PAT = 3;

  function automatic int poly_len(input int idx);
    case (idx)
      0: return 7;
      1: return 23;
      default: return 31;
    endcase
  endfunction

  function automatic int poly_tap(input int idx);
    case (idx)
      0: return 6;
      1: return 18;
      default: return 28;
    endcase
  endfunction

  function automatic logic uses_holdoff(input logic [1:0] sel);
    return (pat_e'(sel) == PAT_P7) || (pat_e'(sel) == PAT_P23);
  endfunction

endpackage

// File: rtl/prbs_word_hist.sv
module prbs_word_hist #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart_i,
  input  logic         take_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] prev2_o,
  output logic [W-1:0] prev1_o,
  output logic         synced_o
);

  logic [1:0] fill_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      fill_q   <= 2'd0;
      synced_o <= 1'b0;
      prev1_o  <= '0;
      prev2_o  <= '0;
    end else if (take_i) begin
      prev2_o <= prev1_o;
      prev1_o <= data_i;
      if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
      if (fill_q >= 2'd1) synced_o <= 1'b1;
    end
  end

  // R2: sync only rises after an accepted word that completes the seed
  a_r2_sync_after_seed: assert property (@(posedge clk) disable iff (rst)
    $rose(synced_o) |-> $past(take_i) && ($past(fill_q) == 2'd1));

  // R8: without restart, sync never drops
  a_r8_no_lock_loss: assert property (@(posedge clk) disable iff (rst)
    (synced_o && !restart_i) |=> synced_o);

  // R10: an idle cycle leaves the history untouched
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!take_i && !restart_i) |=> $stable(prev1_o) && $stable(prev2_o));

endmodule

// File: rtl/prbs_word_predict.sv
module prbs_word_predict
  import prbs_chk_pkg::*;
#(
  parameter int W = 20
) (
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] prev2_i,
  input  logic [W-1:0] prev1_i,
  output logic [W-1:0] expect_o
);

  localparam int SPAN = 3 * W;

  logic [NUM_PAT-1:0][W-1:0] cand;

  for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
    localparam int LEN = poly_len(g);
    localparam int TAP = poly_tap(g);

    if (LEN > 2 * W) begin : g_bad
      initial $error("history shorter than polynomial");
    end

    always_comb begin : p_run
      logic [SPAN-1:0] stream;
      stream = {prev2_i, prev1_i, {W{1'b0}}};
      for (int i = 0; i < W; i++) begin
        stream[W-1-i] = stream[W-1-i+LEN] ^ stream[W-1-i+TAP];
      end
      cand[g] = stream[W-1:0];
    end
  end

  always_comb begin
    case (sel_i)
      2'd0:    expect_o = cand[0];
      2'd1:    expect_o = cand[1];
      default: expect_o = cand[NUM_PAT-1];
    endcase
  end

endmodule

// File: rtl/prbs_cmp_ctrl.sv
module prbs_cmp_ctrl
  import prbs_chk_pkg::*;
#(
  parameter int W          = 20,
  parameter int HOLD_WORDS = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart_i,
  input  logic         valid_i,
  input  logic         synced_i,
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] expect_i,
  output logic         inc_o,
  output logic         err_o
);

  localparam int HW = $clog2(HOLD_WORDS + 1);
  localparam logic [HW-1:0] HOLD_INIT = HW'(HOLD_WORDS);

  logic [HW-1:0] hold_q;
  logic          compare;

  assign compare = valid_i && !restart_i && synced_i && (hold_q == '0);
  assign inc_o   = compare && (data_i != expect_i);

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      hold_q <= '0;
      err_o  <= 1'b0;
    end else begin
      err_o <= inc_o;
      if (inc_o && uses_holdoff(sel_i)) begin
        hold_q <= HOLD_INIT;
      end else if (valid_i && hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
      end
    end
  end

  // R4: no error is reported for a word taken during holdoff
  a_r4_holdoff_quiet: assert property (@(posedge clk) disable iff (rst)
    (hold_q != '0 && valid_i && !restart_i) |=> !err_o);

  // R5: the long pattern never enters holdoff
  a_r5_no_hold_p31: assert property (@(posedge clk) disable iff (rst)
    (sel_i[1] && !restart_i && hold_q == '0) |=> hold_q == '0);

  // R2: nothing is compared before the predictor is seeded
  a_r2_no_early_err: assert property (@(posedge clk) disable iff (rst)
    (!synced_i) |=> !err_o);

endmodule

// File: rtl/prbs_err_cnt.sv
module prbs_err_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (rd_i) begin
      cnt_q <= CNT_W'(inc_i);
    end else if (inc_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
    end else if (rd_i) begin
      count_o <= cnt_q;
    end
  end

  // R6: a full counter stays full until read or cleared
  a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && !rd_i && !clr_i) |=> cnt_q == CNT_MAX);

  // R3: the count grows by at most one per cycle
  a_r3_one_per_word: assert property (@(posedge clk) disable iff (rst)
    (!rd_i && !clr_i) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

  // R7: a read returns the old value and restarts the count
  a_r7_read_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !clr_i) |=> (count_o == $past(cnt_q)) && (cnt_q <= CNT_W'(1)));

  // R9: a clear leaves zero behind
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> cnt_q == '0);

endmodule

// File: rtl/prbs_word_checker.sv
module prbs_word_checker
  import prbs_chk_pkg::*;
#(
  parameter int W          = 20,
  parameter int CNT_W      = 16,
  parameter int HOLD_WORDS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [1:0]       pat_sel_i,
  input  logic [W-1:0]     data_i,
  input  logic             valid_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] count_o,
  output logic             sync_o,
  output logic             err_o
);

  logic [1:0]   sel_q;
  logic         restart;
  logic [W-1:0] prev1, prev2, expect_w;
  logic         synced, inc;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 2'd0;
    else     sel_q <= pat_sel_i;
  end

  assign restart = !en_i || (pat_sel_i != sel_q);

  prbs_word_hist #(.W(W)) hist_i (
    .clk      (clk),
    .rst      (rst),
    .restart_i(restart),
    .take_i   (valid_i && !restart),
    .data_i   (data_i),
    .prev2_o  (prev2),
    .prev1_o  (prev1),
    .synced_o (synced)
  );

  prbs_word_predict #(.W(W)) pred_i (
    .sel_i   (pat_sel_i),
    .prev2_i (prev2),
    .prev1_i (prev1),
    .expect_o(expect_w)
  );

  prbs_cmp_ctrl #(.W(W), .HOLD_WORDS(HOLD_WORDS)) cmp_i (
    .clk      (clk),
    .rst      (rst),
    .restart_i(restart),
    .valid_i  (valid_i),
    .synced_i (synced),
    .sel_i    (pat_sel_i),
    .data_i   (data_i),
    .expect_i (expect_w),
    .inc_o    (inc),
    .err_o    (err_o)
  );

  prbs_err_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (restart),
    .inc_i  (inc),
    .rd_i   (rd_i),
    .count_o(count_o)
  );

  assign sync_o = synced;

  // R9: disable or a select change drops sync at the next edge
  a_r9_restart_drop: assert property (@(posedge clk) disable iff (rst)
    restart |=> !sync_o);

  // R3: an error pulse only follows an accepted word
  a_r3_err_needs_word: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(valid_i) && $past(sync_o));

endmodule

// File: tb/prbs_word_checker_tb_top.sv
module prbs_word_checker_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        en_i;
  logic [1:0]  pat_sel_i;
  logic [19:0] data_i;
  logic        valid_i;
  logic        rd_i;
  logic [15:0] count_o;
  logic        sync_o;
  logic        err_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [63:0] g_hist = '1;
  int g_len = 7;
  int g_tap = 6;

  always #4 clk = ~clk;

  prbs_word_checker dut_i (
    .clk(clk), .rst(rst), .en_i(en_i), .pat_sel_i(pat_sel_i),
    .data_i(data_i), .valid_i(valid_i), .rd_i(rd_i),
    .count_o(count_o), .sync_o(sync_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_word(output logic [19:0] w);
    logic nb;
    for (int b = 0; b < 20; b++) begin
      nb = g_hist[g_len-1] ^ g_hist[g_tap-1];
      g_hist = {g_hist[62:0], nb};
      w[19-b] = nb;
    end
  endtask

  task automatic send(input logic [19:0] w);
    data_i = w; valid_i = 1'b1; rd_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_good(input logic [19:0] flip);
    logic [19:0] w;
    next_word(w);
    send(w ^ flip);
  endtask

  task automatic idle();
    valid_i = 1'b0; rd_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_read(output int v);
    valid_i = 1'b0; rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    v = int'(count_o);
  endtask

  task automatic restart(input logic [1:0] sel);
    en_i = 1'b0; pat_sel_i = sel; valid_i = 1'b0; rd_i = 1'b0;
    @(negedge clk);
    en_i = 1'b1;
    case (sel)
      2'd0: begin g_len = 7;  g_tap = 6;  end
      2'd1: begin g_len = 23; g_tap = 18; end
      default: begin g_len = 31; g_tap = 28; end
    endcase
  endtask

  task automatic t_reset();
    chk(count_o == 16'd0, "R7 reset count", int'(count_o), 0);
    chk(sync_o == 1'b0, "R2 reset sync", int'(sync_o), 0);
    chk(err_o == 1'b0, "R3 reset err", int'(err_o), 0);
  endtask

  task automatic t_clean(input logic [1:0] sel);
    int v;
    int errs = 0;
    restart(sel);
    send_good('0);
    chk(sync_o == 1'b0, "R2 sync after one word", int'(sync_o), 0);
    send_good('0);
    chk(sync_o == 1'b1, "R2 sync after two words", int'(sync_o), 1);
    for (int i = 0; i < 40; i++) begin
      send_good('0);
      if (err_o) errs++;
    end
    chk(errs == 0, "R1 clean stream pulses", errs, 0);
    do_read(v);
    chk(v == 0, "R1 clean stream count", v, 0);
  endtask

  task automatic t_multi_bit();
    int v;
    restart(2'd1);
    repeat (4) send_good('0);
    send_good(20'h00070);
    chk(err_o == 1'b1, "R3 pulse on errored word", int'(err_o), 1);
    send_good('0);
    chk(err_o == 1'b0, "R3 pulse one cycle", int'(err_o), 0);
    repeat (10) send_good('0);
    do_read(v);
    chk(v == 1, "R3 three bad bits count once", v, 1);
  endtask

  task automatic t_holdoff();
    int v;
    restart(2'd0);
    repeat (4) send_good('0);
    send_good(20'h00100);
    send_good(20'h01000);
    repeat (10) send_good('0);
    do_read(v);
    chk(v == 1, "R4 error in holdoff ignored", v, 1);
    restart(2'd0);
    repeat (42) send(20'hAAAAA);
    do_read(v);
    chk(v == 10, "R4 wrong pattern with holdoff", v, 10);
  endtask

  task automatic t_p31_flip();
    int v;
    restart(2'd2);
    repeat (4) send_good('0);
    send_good(20'h80000);
    repeat (8) send_good('0);
    do_read(v);
    chk(v == 2, "R5 single flip multiplies", v, 2);
  endtask

  task automatic t_read_same_cycle();
    int v;
    restart(2'd3);
    repeat (6) send(20'hAAAAA);
    data_i = 20'hAAAAA; valid_i = 1'b1; rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    chk(count_o == 16'd4, "R7 read returns prior count", int'(count_o), 4);
    do_read(v);
    chk(v == 1, "R7 same-cycle error kept", v, 1);
    do_read(v);
    chk(v == 0, "R7 cleared after read", v, 0);
  endtask

  task automatic t_saturate();
    int v;
    restart(2'd2);
    repeat (2) send(20'hAAAAA);
    for (int i = 0; i < 65540; i++) send(20'hAAAAA);
    chk(sync_o == 1'b1, "R8 sync kept through errors", int'(sync_o), 1);
    do_read(v);
    chk(v == 65535, "R6 saturated count", v, 65535);
    do_read(v);
    chk(v == 0, "R7 clear after saturation", v, 0);
    repeat (100) send(20'hAAAAA);
    do_read(v);
    chk(v == 100, "R8 every wrong word counted", v, 100);
  endtask

  task automatic t_restart();
    int v;
    restart(2'd2);
    repeat (7) send(20'hAAAAA);
    pat_sel_i = 2'd1; valid_i = 1'b0;
    @(negedge clk);
    chk(sync_o == 1'b0, "R9 select change drops sync", int'(sync_o), 0);
    do_read(v);
    chk(v == 0, "R9 select change clears count", v, 0);
    restart(2'd2);
    repeat (7) send(20'hAAAAA);
    en_i = 1'b0; valid_i = 1'b0;
    @(negedge clk);
    chk(sync_o == 1'b0, "R9 disable drops sync", int'(sync_o), 0);
    do_read(v);
    chk(v == 0, "R9 disable clears count", v, 0);
  endtask

  task automatic t_invalid();
    int v;
    int errs = 0;
    restart(2'd1);
    for (int i = 0; i < 20; i++) begin
      send_good('0);
      if (err_o) errs++;
      data_i = 20'h5A5A5 ^ 20'(i * 977); valid_i = 1'b0;
      @(negedge clk);
      if (err_o) errs++;
    end
    chk(errs == 0, "R10 idle words no pulse", errs, 0);
    do_read(v);
    chk(v == 0, "R10 idle words no count", v, 0);
  endtask

  initial begin
    rst = 1'b1; en_i = 1'b0; pat_sel_i = 2'd0; data_i = '0;
    valid_i = 1'b0; rd_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean(2'd0);
    t_clean(2'd1);
    t_clean(2'd2);
    t_multi_bit();
    t_holdoff();
    t_p31_flip();
    t_read_same_cycle();
    t_restart();
    t_invalid();
    t_saturate();
    idle();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule